// File: doc/BRIEF.md
# Multi-source latched interrupt controller

This block merges three kinds of interrupt source from a 24-line digital I/O port set into one latched interrupt request. Each of four port groups (port A, port B, and the low and high nybbles of port C) can raise a request when any of its lines changes level in either direction. A rising edge on a chosen trigger line of port C, and a rising edge on an external counter output, are the other two sources. All port, counter and enable-pin inputs are first passed through a synchronizer; edges are detected on the synchronized values.

Software controls the block through a small write interface with four targets selected by `cfg_addr`: a group mask register (a 0 bit enables a group), an edge-enable register, a global-disable strobe and a clear strobe. The latched request is held until cleared. An external allow pin, pulled high at board level, blocks every source while low. Two readback buses show the mask and the edge-enable register with the pin state and the pending flag folded in. Bus decoding and interrupt delivery upstream are outside this block.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, `mask_rd` reads 0x0F (all groups off), `edge_rd` bits 1:0 read 0, and line changes on any port or the counter set no request.
- R2: A write with `cfg_addr`=0 loads the group mask from `cfg_wdata[3:0]`: bit 0 port A, bit 1 port B, bit 2 port C lines 3:0, bit 3 port C lines 7:4; a 0 enables the group. `mask_rd[7:4]` always read 0 whatever was written.
- R3: With a group enabled, any rising or falling change on one of its lines sets the pending flag; the flag shows on `irq_out` after the third rising clock edge following the input change (two synchronizer stages plus the latch) and not after the second. A change on a disabled group sets nothing.
- R4: A write with `cfg_addr`=1 and `cfg_wdata[0]`=1 enables a request on a rising edge of port C line 3; a falling edge on that line never requests through this source.
- R5: `cfg_wdata[1]`=1 in the same register enables a request on a rising edge of `ctr_out`; a falling edge never requests.
- R6: `edge_rd` reads bit 0 trigger enable, bit 1 counter enable, bit 4 the synchronized allow pin, bit 5 the pending flag (1 = latched); bits 7:6 and 3:2 read 0.
- R7: A write of any data with `cfg_addr`=2 sets all four mask bits to 1 and clears both edge-enable bits, leaving an already pending flag set.
- R8: A write of any data with `cfg_addr`=3 clears the pending flag; otherwise a set flag holds indefinitely.
- R9: When a qualified source event and a clear write fall on the same clock edge, the flag stays set.
- R10: While the synchronized allow pin `irq_allow` is low no source sets the flag; once it is high again, sources act normally and changes seen while it was low leave no stale request.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_a_in | input | 8 | Port A line levels |
| port_b_in | input | 8 | Port B line levels |
| port_c_in | input | 8 | Port C line levels |
| ctr_out | input | 1 | Counter output line |
| irq_allow | input | 1 | External allow pin, low blocks all sources |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_addr | input | 2 | Write target: 0 mask, 1 edge enable, 2 global disable, 3 clear |
| cfg_wdata | input | 8 | Write data |
| mask_rd | output | 8 | Group mask readback |
| edge_rd | output | 8 | Edge enables, allow pin and pending flag |
| irq_out | output | 1 | Latched interrupt request |

## Verification
The bench sweeps every one of the 16 mask values against a toggle of every one of the 24 port lines, so a design that maps a line to the wrong group or inverts the enable polarity raises a request where none is due, and it checks the request is absent one edge early, catching a missing or extra synchronizer stage. Rising and falling edges on the trigger line and the counter are run under all four edge-enable settings, exposing a design that fires on both edges. It lines up a clear write with an event on the same edge, where a clear-wins latch would drop the request, and issues a global disable with a request already pending, where a design that also cleared the flag would lose it. Changes made while the allow pin is low must leave nothing behind once the pin rises, which a design that stopped tracking line history while blocked would get wrong.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int NUM_GROUPS = 4;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_EDGE = 2'd1,
    SEL_GDIS = 2'd2,
    SEL_CLR  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
  parameter int W       = 8,
  parameter int STAGES  = 2,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= {W{RST_ONE}};
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= {W{RST_ONE}};
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect
  import irq_merge_pkg::*;
#(
  parameter int PORT_W   = 8,
  parameter int TRIG_BIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3*PORT_W-1:0]   lines,
  input  logic                  ctr,
  output logic [NUM_GROUPS-1:0] grp_chg,
  output logic                  trig_rise,
  output logic                  ctr_rise
);
  localparam int NIB   = PORT_W / 2;
  localparam int ALL_W = 3 * PORT_W;
  localparam int TRIG_IDX = 2 * PORT_W + TRIG_BIT;

  function automatic int grp_lo(input int g);
    case (g)
      0:       return 0;
      1:       return PORT_W;
      2:       return 2 * PORT_W;
      default: return 2 * PORT_W + NIB;
    endcase
  endfunction

  function automatic int grp_w(input int g);
    return (g < 2) ? PORT_W : NIB;
  endfunction

  logic [ALL_W-1:0] prev_lines;
  logic             prev_ctr;
  logic [ALL_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lines <= '0;
      prev_ctr   <= 1'b0;
    end else begin
      prev_lines <= lines;
      prev_ctr   <= ctr;
    end
  end

  assign diff = lines ^ prev_lines;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int WD = grp_w(g);
    assign grp_chg[g] = |diff[LO +: WD];
  end

  assign trig_rise = lines[TRIG_IDX] & ~prev_lines[TRIG_IDX];
  assign ctr_rise  = ctr & ~prev_ctr;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_merge_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [1:0]            addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_GROUPS-1:0] grp_off,
  output logic                  trig_en,
  output logic                  ctr_en,
  output logic                  clr_pulse
);
  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_off <= '1;
      trig_en <= 1'b0;
      ctr_en  <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_MASK: grp_off <= wdata[NUM_GROUPS-1:0];
        SEL_EDGE: begin
          trig_en <= wdata[0];
          ctr_en  <= wdata[1];
        end
        SEL_GDIS: begin
          grp_off <= '1;
          trig_en <= 1'b0;
          ctr_en  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign clr_pulse = wr && (sel == SEL_CLR);

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:NUM_GROUPS];
endmodule

// File: rtl/irq_pending_latch.sv
module irq_pending_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end
endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_a_in,
  input  logic [PORT_W-1:0] port_b_in,
  input  logic [PORT_W-1:0] port_c_in,
  input  logic              ctr_out,
  input  logic              irq_allow,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] mask_rd,
  output logic [DATA_W-1:0] edge_rd,
  output logic              irq_out
);
  localparam int ALL_W = 3 * PORT_W;

  logic [ALL_W-1:0]      lines_s;
  logic                  ctr_s;
  logic                  allow_s;
  logic [NUM_GROUPS-1:0] grp_chg;
  logic                  trig_rise, ctr_rise;
  logic [NUM_GROUPS-1:0] grp_off;
  logic                  trig_en, ctr_en, clr_pulse;
  logic                  any_evt;
  logic                  pend;

  irq_in_sync #(.W(ALL_W), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_sync_lines (
    .clk(clk), .rst_n(rst_n),
    .d({port_c_in, port_b_in, port_a_in}), .q(lines_s)
  );

  irq_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_sync_ctr (
    .clk(clk), .rst_n(rst_n), .d(ctr_out), .q(ctr_s)
  );

  irq_in_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_sync_allow (
    .clk(clk), .rst_n(rst_n), .d(irq_allow), .q(allow_s)
  );

  irq_change_detect #(.PORT_W(PORT_W), .TRIG_BIT(TRIG_BIT)) u_detect (
    .clk(clk), .rst_n(rst_n), .lines(lines_s), .ctr(ctr_s),
    .grp_chg(grp_chg), .trig_rise(trig_rise), .ctr_rise(ctr_rise)
  );

  irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .grp_off(grp_off), .trig_en(trig_en), .ctr_en(ctr_en), .clr_pulse(clr_pulse)
  );

  assign any_evt = allow_s & ( (|(grp_chg & ~grp_off))
                             | (trig_rise & trig_en)
                             | (ctr_rise & ctr_en) );

  irq_pending_latch u_pend (
    .clk(clk), .rst_n(rst_n), .set(any_evt), .clr(clr_pulse), .pend(pend)
  );

  always_comb begin
    mask_rd = '0;
    mask_rd[NUM_GROUPS-1:0] = grp_off;
    edge_rd    = '0;
    edge_rd[0] = trig_en;
    edge_rd[1] = ctr_en;
    edge_rd[4] = allow_s;
    edge_rd[5] = pend;
  end

  assign irq_out = pend;
endmodule

// File: rtl/irq_merge_ctrl_chk.sv
module irq_merge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_addr,
  input logic [7:0] mask_rd,
  input logic [7:0] edge_rd,
  input logic       irq_out,
  input logic       any_evt
);
  // R1: state seen on the edge after reset is held
  a_r1_reset_vals: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && mask_rd == 8'h0F && edge_rd[1:0] == 2'b00));

  // R7: global disable turns every source off
  a_r7_gdis_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2) |=> (mask_rd[3:0] == 4'hF && edge_rd[1:0] == 2'b00));

  // R7: global disable keeps a pending request
  a_r7_gdis_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd2 && irq_out) |=> irq_out);

  // R8: clear with no competing event drops the request
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd3 && !any_evt) |=> !irq_out);

  // R8: request holds without a clear
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(cfg_wr && cfg_addr == 2'd3)) |=> irq_out);

  // R9: a qualified event always leaves the request set
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> irq_out);
endmodule

bind irq_merge_ctrl irq_merge_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .mask_rd(mask_rd), .edge_rd(edge_rd), .irq_out(irq_out), .any_evt(any_evt)
);

// File: tb/irq_merge_ctrl_bench.sv
module irq_merge_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pv = '0;
  logic        ctr = 1'b0;
  logic        allow = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  mask_rd, edge_rd;
  logic        irq_out;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_merge_ctrl u_irq_merge_ctrl (
    .clk(clk), .rst_n(rst_n),
    .port_a_in(pv[7:0]), .port_b_in(pv[15:8]), .port_c_in(pv[23:16]),
    .ctr_out(ctr), .irq_allow(allow),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mask_rd(mask_rd), .edge_rd(edge_rd), .irq_out(irq_out)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int grp_of(input int idx);
    if (idx < 8)  return 0;
    if (idx < 16) return 1;
    if (idx < 20) return 2;
    return 3;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    check("R1 reset irq", {7'd0, irq_out}, 8'h00);
    check("R1 reset mask", mask_rd, 8'h0F);
    check("R1 reset edge", edge_rd, 8'h10);
    rst_n = 1'b1;
    tick(3);
    // R1: nothing triggers with the reset configuration
    pv = 24'hFFFFFF; ctr = 1'b1;
    tick(5);
    check("R1 no source after reset", {7'd0, irq_out}, 8'h00);
    pv = '0; ctr = 1'b0;
    tick(5);
    check("R1 no source on fall", {7'd0, irq_out}, 8'h00);

    // R2/R3: every mask against every line
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, {4'hA, m[3:0]});
      check("R2 mask readback", mask_rd, {4'h0, m[3:0]});
      for (int b = 0; b < 24; b++) begin
        pv[b] = ~pv[b];
        tick(2);
        check("R3 not before third edge", {7'd0, irq_out}, 8'h00);
        tick();
        check("R3 change request", {7'd0, irq_out}, {7'd0, ~m[grp_of(b)]});
        wr(2'd3, 8'h00);
        check("R8 clear", {7'd0, irq_out}, 8'h00);
      end
    end

    // R4/R5: edge sources under every enable pair
    wr(2'd0, 8'h0F);
    pv = '0; ctr = 1'b0;
    tick(4);
    wr(2'd3, 8'h00);
    for (int e = 0; e < 4; e++) begin
      wr(2'd1, {6'd0, e[1:0]});
      check("R6 edge enable readback", edge_rd, {8'h10 | {6'd0, e[1:0]}});
      pv[19] = 1'b1;
      tick(3);
      check("R4 trigger rise", {7'd0, irq_out}, {7'd0, e[0]});
      wr(2'd3, 8'h00);
      pv[19] = 1'b0;
      tick(3);
      check("R4 trigger fall ignored", {7'd0, irq_out}, 8'h00);
      ctr = 1'b1;
      tick(3);
      check("R5 counter rise", {7'd0, irq_out}, {7'd0, e[1]});
      check("R6 pending bit", {7'd0, edge_rd[5]}, {7'd0, e[1]});
      wr(2'd3, 8'h00);
      ctr = 1'b0;
      tick(3);
      check("R5 counter fall ignored", {7'd0, irq_out}, 8'h00);
      // R4: other port C lines do not act as the trigger
      pv[18] = 1'b1;
      tick(3);
      check("R4 other line no trigger", {7'd0, irq_out}, 8'h00);
      pv[18] = 1'b0;
      tick(3);
    end

    // R10: allow pin gates all sources
    allow = 1'b0;
    tick(3);
    check("R10 allow readback low", edge_rd, 8'h03);
    wr(2'd0, 8'h00);
    pv[0] = 1'b1; pv[19] = 1'b1; ctr = 1'b1;
    tick(5);
    check("R10 blocked", {7'd0, irq_out}, 8'h00);
    allow = 1'b1;
    tick(4);
    check("R10 no stale request", {7'd0, irq_out}, 8'h00);
    check("R10 allow readback high", {7'd0, edge_rd[4]}, 8'h01);
    pv[8] = 1'b1;
    tick(3);
    check("R10 restored", {7'd0, irq_out}, 8'h01);

    // R8: holds
    tick(10);
    check("R8 holds", {7'd0, irq_out}, 8'h01);

    // R7: global disable keeps pending, disables sources
    wr(2'd2, 8'h5C);
    check("R7 pending kept", {7'd0, irq_out}, 8'h01);
    check("R7 mask", mask_rd, 8'h0F);
    check("R7 edge", edge_rd, 8'h30);
    wr(2'd3, 8'h77);
    check("R8 clear any data", {7'd0, irq_out}, 8'h00);
    pv = ~pv; ctr = 1'b0;
    tick(2);
    ctr = 1'b1;
    tick(4);
    check("R7 sources off", {7'd0, irq_out}, 8'h00);

    // R9: event and clear on the same edge
    wr(2'd0, 8'h0E);
    tick(2);
    wr(2'd3, 8'h00);
    pv[3] = ~pv[3];
    tick(2);
    wr(2'd3, 8'h00);
    check("R9 event beats clear", {7'd0, irq_out}, 8'h01);
    wr(2'd3, 8'h00);
    check("R8 clear after tie", {7'd0, irq_out}, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule